// File: doc/BRIEF.md
# Serial Channel Bit-Clock Generator

This block derives the receive and transmit bit-clock enables for one serial channel. All timing runs on a single system clock. Every clock source reaches the block as a one-cycle tick on that clock: a dedicated receive-clock pin, a dedicated transmit-clock pin, and an oscillator tick. A programmable baud divider divides a selected source by 16·k. A second divide-by-16 stage can bring the divider output down from a 16x sample rate to the bit rate.

A 3-bit mode value and a variant bit pick the source that feeds the divider. They also pick what drives the receive enable and the transmit enable. When the divider feeds a phase-tracking receiver, the block also brings out the 16x sample enable. The division factor comes from a pair of extra register bits and an 8-bit divider register, using either a standard layout or an enhanced layout. Every output is registered.

Top module: `sccg_clkgen`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, all three outputs are low. All divider counters return to zero.
- R2: With `div_en` low the division factor k is 1, so the divider output pulses once every 16 ticks of its source.
- R3: With `div_en` high and `enh_en` low, N = {`ext_bits`[1:0], `div_reg`[7:0]} (10 bits) and k = 2·(N+1).
- R4: With `div_en` and `enh_en` high, N = `div_reg`[5:0], M = {`ext_bits`[1:0], `div_reg`[7:6]} and k = 2·(N+1)·M. An M of 0 is used as 1.
- R5: Mode 0 (`clk_mode`=0): rx follows the rx pin. With `sub_b`=0, tx follows the tx pin. With `sub_b`=1, tx is the divider output driven by the oscillator tick.
- R6: Mode 1: rx and tx both follow the rx pin.
- R7: Modes 2 and 6: the divider is driven by the rx pin (mode 2) or by the oscillator (mode 6), and rx is its output divided by a further 16. With `sub_b`=0, tx follows the tx pin. With `sub_b`=1, tx equals rx.
- R8: Modes 3 and 7: the divider is driven by the rx pin (mode 3) or by the oscillator (mode 7). rx is the divider output divided by 16 when `sub_b`=0, and the divider output itself when `sub_b`=1. tx always equals rx.
- R9: Mode 4: rx and tx both follow the oscillator tick. Mode 5: rx and tx both follow the rx pin.
- R10: `samp16_en` is the divider output in modes 2, 3, 6 and 7. It is low in every other mode.
- R11: Each output pulse appears exactly one cycle after the source tick that causes it.
- R12: In a cycle where any configuration input differs from its value in the previous cycle, that cycle's ticks are dropped, all outputs are low in the next cycle, and all counters restart from zero. The first tick after the change counts as tick one. The configuration is taken as all-zero during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_pin_tick | input | 1 | One-cycle tick from the receive-clock pin |
| tx_pin_tick | input | 1 | One-cycle tick from the transmit-clock pin |
| xtal_tick | input | 1 | One-cycle tick from the oscillator |
| clk_mode | input | 3 | Clock mode 0..7 |
| sub_b | input | 1 | Variant select: 0 for a, 1 for b |
| div_en | input | 1 | Enables the programmable factor k |
| enh_en | input | 1 | Selects the enhanced divisor layout |
| ext_bits | input | HI_W | Two extra divisor bits |
| div_reg | input | LO_W | Divider register |
| rx_bit_en | output | 1 | Receive bit enable |
| tx_bit_en | output | 1 | Transmit bit enable |
| samp16_en | output | 1 | 16x sample enable |

## Verification
Every output is due exactly one clock after the posedge that samples the tick causing it. A change of configuration forces all outputs low for that same single following cycle. The bench drives ticks and configuration on the falling edge. On each falling edge it first compares all three outputs with what its model predicted from the inputs it drove one cycle earlier, and only then drives the next inputs. Separate pulse-count checks in runs with a tick on every cycle confirm the absolute division factors from closed-form counts.

// File: rtl/sccg_pkg.sv
package sccg_pkg;

  typedef enum logic [2:0] {
    CM_PINS      = 3'd0,
    CM_RX_BOTH   = 3'd1,
    CM_RXDIV_BIT = 3'd2,
    CM_RXDIV     = 3'd3,
    CM_XT_BOTH   = 3'd4,
    CM_RX_ALT    = 3'd5,
    CM_XTDIV_BIT = 3'd6,
    CM_XTDIV     = 3'd7
  } clk_mode_e;

endpackage

// File: rtl/sccg_factor.sv
module sccg_factor #(
  parameter int HI_W = 2,
  parameter int LO_W = 8,
  parameter int EN_W = 6,
  parameter int K_W  = HI_W + LO_W + 2
) (
  input  logic [HI_W-1:0] ext_bits,
  input  logic [LO_W-1:0] div_reg,
  input  logic            div_en,
  input  logic            enh_en,
  output logic [K_W-1:0]  k
);
  localparam int M_W = HI_W + LO_W - EN_W;

  logic [K_W-1:0] std_n1, k_std;
  logic [K_W-1:0] enh_n1, m_eff, k_enh;
  logic [M_W-1:0] m_raw;

  // standard layout: N = {extra, register}
  assign std_n1 = K_W'({ext_bits, div_reg}) + K_W'(1);
  assign k_std  = std_n1 << 1;

  // enhanced layout: N = low bits, M = {extra, register top bits}
  assign enh_n1 = K_W'(div_reg[EN_W-1:0]) + K_W'(1);
  assign m_raw  = {ext_bits, div_reg[LO_W-1:EN_W]};
  assign m_eff  = (m_raw == '0) ? K_W'(1) : K_W'(m_raw);
  assign k_enh  = (enh_n1 * m_eff) << 1;

  always_comb begin
    if (!div_en)      k = K_W'(1);
    else if (!enh_en) k = k_std;
    else              k = k_enh;
  end
endmodule

// File: rtl/sccg_tick_div.sv
module sccg_tick_div #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         tick,
  input  logic [W-1:0] limit,
  output logic         tc
);
  logic [W-1:0] cnt;
  logic         at_end;

  assign at_end = (cnt >= limit - W'(1));
  assign tc     = tick & at_end;

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt <= '0;
    else if (tick)   cnt <= at_end ? '0 : cnt + W'(1);
  end
endmodule

// File: rtl/sccg_route.sv
module sccg_route
  import sccg_pkg::*;
(
  input  logic [2:0] mode,
  input  logic       sub_b,
  input  logic       rxp,
  input  logic       txp,
  input  logic       xt,
  input  logic       gen,
  input  logic       post,
  output logic       brg_src,
  output logic       rx_d,
  output logic       tx_d,
  output logic       samp_d
);
  clk_mode_e m;
  assign m = clk_mode_e'(mode);

  // divider source: oscillator for modes 0,6,7, rx pin for 2,3
  assign brg_src = (m == CM_RXDIV_BIT || m == CM_RXDIV) ? rxp :
                   (m == CM_PINS || m == CM_XTDIV_BIT || m == CM_XTDIV) ? xt : 1'b0;

  always_comb begin
    rx_d   = 1'b0;
    tx_d   = 1'b0;
    samp_d = 1'b0;
    case (m)
      CM_PINS: begin
        rx_d = rxp;
        tx_d = sub_b ? gen : txp;
      end
      CM_RX_BOTH, CM_RX_ALT: begin
        rx_d = rxp;
        tx_d = rxp;
      end
      CM_XT_BOTH: begin
        rx_d = xt;
        tx_d = xt;
      end
      CM_RXDIV_BIT, CM_XTDIV_BIT: begin
        rx_d   = post;
        tx_d   = sub_b ? post : txp;
        samp_d = gen;
      end
      CM_RXDIV, CM_XTDIV: begin
        rx_d   = sub_b ? gen : post;
        tx_d   = sub_b ? gen : post;
        samp_d = gen;
      end
      default: begin
        rx_d = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/sccg_clkgen.sv
module sccg_clkgen #(
  parameter int HI_W     = 2,
  parameter int LO_W     = 8,
  parameter int EN_W     = 6,
  parameter int SUB_LOG2 = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rx_pin_tick,
  input  logic            tx_pin_tick,
  input  logic            xtal_tick,
  input  logic [2:0]      clk_mode,
  input  logic            sub_b,
  input  logic            div_en,
  input  logic            enh_en,
  input  logic [HI_W-1:0] ext_bits,
  input  logic [LO_W-1:0] div_reg,
  output logic            rx_bit_en,
  output logic            tx_bit_en,
  output logic            samp16_en
);
  localparam int STD_W   = HI_W + LO_W;
  localparam int K_W     = STD_W + 2;
  localparam int CFG_W   = 3 + 3 + HI_W + LO_W;
  localparam int SW      = SUB_LOG2 + 1;
  localparam int NUM_STG = 2;
  localparam logic [SW-1:0] SUB_LIM = SW'(2 ** SUB_LOG2);

  logic [CFG_W-1:0] cfg, cfg_q;
  logic             chg;
  logic [K_W-1:0]   k;
  logic             brg_src, pre_tc;
  logic [NUM_STG:0] stg;
  logic             rx_d, tx_d, samp_d;

  assign cfg = {clk_mode, sub_b, div_en, enh_en, ext_bits, div_reg};
  assign chg = (cfg != cfg_q);

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else     cfg_q <= cfg;
  end

  sccg_factor #(.HI_W(HI_W), .LO_W(LO_W), .EN_W(EN_W), .K_W(K_W)) u_factor (
    .ext_bits (ext_bits),
    .div_reg  (div_reg),
    .div_en   (div_en),
    .enh_en   (enh_en),
    .k        (k)
  );

  sccg_tick_div #(.W(K_W)) u_pre (
    .clk   (clk),
    .rst   (rst),
    .clr   (chg),
    .tick  (brg_src & ~chg),
    .limit (k),
    .tc    (pre_tc)
  );

  assign stg[0] = pre_tc;

  // stage 0: 16x to divider output, stage 1: divider output to bit rate
  for (genvar i = 0; i < NUM_STG; i++) begin : g_stage
    sccg_tick_div #(.W(SW)) u_div (
      .clk   (clk),
      .rst   (rst),
      .clr   (chg),
      .tick  (stg[i]),
      .limit (SUB_LIM),
      .tc    (stg[i+1])
    );
  end

  sccg_route u_route (
    .mode    (clk_mode),
    .sub_b   (sub_b),
    .rxp     (rx_pin_tick),
    .txp     (tx_pin_tick),
    .xt      (xtal_tick),
    .gen     (stg[1]),
    .post    (stg[2]),
    .brg_src (brg_src),
    .rx_d    (rx_d),
    .tx_d    (tx_d),
    .samp_d  (samp_d)
  );

  always_ff @(posedge clk) begin
    if (rst || chg) begin
      rx_bit_en <= 1'b0;
      tx_bit_en <= 1'b0;
      samp16_en <= 1'b0;
    end else begin
      rx_bit_en <= rx_d;
      tx_bit_en <= tx_d;
      samp16_en <= samp_d;
    end
  end
endmodule

// File: rtl/sccg_clkgen_chk.sv
module sccg_clkgen_chk #(
  parameter int HI_W = 2,
  parameter int LO_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            rx_pin_tick,
  input logic            tx_pin_tick,
  input logic            xtal_tick,
  input logic [2:0]      clk_mode,
  input logic            sub_b,
  input logic            div_en,
  input logic            enh_en,
  input logic [HI_W-1:0] ext_bits,
  input logic [LO_W-1:0] div_reg,
  input logic            rx_bit_en,
  input logic            tx_bit_en,
  input logic            samp16_en
);
  localparam int CW = 6 + HI_W + LO_W;
  logic [CW-1:0] seen_cfg;
  logic          moved;

  always_ff @(posedge clk) begin
    if (rst) seen_cfg <= '0;
    else     seen_cfg <= {clk_mode, sub_b, div_en, enh_en, ext_bits, div_reg};
  end
  assign moved = ({clk_mode, sub_b, div_en, enh_en, ext_bits, div_reg} != seen_cfg);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!rx_bit_en && !tx_bit_en && !samp16_en));

  // R12
  cfg_change_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    moved |=> (!rx_bit_en && !tx_bit_en && !samp16_en));

  // R5
  mode0a_pins_chk: assert property (@(posedge clk) disable iff (rst)
    (!moved && clk_mode == 3'd0 && !sub_b) |=>
      (rx_bit_en == $past(rx_pin_tick) && tx_bit_en == $past(tx_pin_tick)));

  // R6
  mode1_rxpin_chk: assert property (@(posedge clk) disable iff (rst)
    (!moved && clk_mode == 3'd1) |=>
      (rx_bit_en == $past(rx_pin_tick) && tx_bit_en == $past(rx_pin_tick)));

  // R9
  mode4_xtal_chk: assert property (@(posedge clk) disable iff (rst)
    (!moved && clk_mode == 3'd4) |=>
      (rx_bit_en == $past(xtal_tick) && tx_bit_en == $past(xtal_tick)));

  // R8
  mode3_tx_eq_rx_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_mode[1:0] == 2'b11) |=> (tx_bit_en == rx_bit_en));

  // R7
  mode2_bit_in_samp_chk: assert property (@(posedge clk) disable iff (rst)
    (clk_mode[1:0] == 2'b10) |=> (!rx_bit_en || samp16_en));

  // R10
  samp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!clk_mode[1]) |=> !samp16_en);
endmodule

bind sccg_clkgen sccg_clkgen_chk #(.HI_W(HI_W), .LO_W(LO_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .rx_pin_tick (rx_pin_tick),
  .tx_pin_tick (tx_pin_tick),
  .xtal_tick   (xtal_tick),
  .clk_mode    (clk_mode),
  .sub_b       (sub_b),
  .div_en      (div_en),
  .enh_en      (enh_en),
  .ext_bits    (ext_bits),
  .div_reg     (div_reg),
  .rx_bit_en   (rx_bit_en),
  .tx_bit_en   (tx_bit_en),
  .samp16_en   (samp16_en)
);

// File: tb/sccg_clkgen_tb.sv
`timescale 1ns/1ps
module sccg_clkgen_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_pin_tick = 0, tx_pin_tick = 0, xtal_tick = 0;
  logic [2:0] clk_mode = 0;
  logic sub_b = 0, div_en = 0, enh_en = 0;
  logic [1:0] ext_bits = 0;
  logic [7:0] div_reg = 0;
  logic rx_bit_en, tx_bit_en, samp16_en;

  always #2.5 clk = ~clk;

  sccg_clkgen u_dut (
    .clk(clk), .rst(rst), .rx_pin_tick(rx_pin_tick), .tx_pin_tick(tx_pin_tick),
    .xtal_tick(xtal_tick), .clk_mode(clk_mode), .sub_b(sub_b), .div_en(div_en),
    .enh_en(enh_en), .ext_bits(ext_bits), .div_reg(div_reg),
    .rx_bit_en(rx_bit_en), .tx_bit_en(tx_bit_en), .samp16_en(samp16_en)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // pending configuration, applied at the next drive point
  logic nr = 1; logic [2:0] nm = 0; logic ns = 0, nd = 0, ne = 0;
  logic [1:0] nx = 0; logic [7:0] nv = 0;

  // reference model state
  int pre_c = 0, s16_c = 0, post_c = 0;
  logic [15:0] prev_cfg = 0;
  logic e_rx = 0, e_tx = 0, e_sm = 0;

  function automatic int factor();
    int n, m;
    if (!div_en) return 1;
    if (!enh_en) return (ext_bits * 256 + div_reg + 1) * 2;
    n = div_reg % 64;
    m = ext_bits * 4 + div_reg / 64;
    if (m == 0) m = 1;
    return (n + 1) * 2 * m;
  endfunction

  task automatic model_step();
    logic [15:0] cur;
    logic src, g, p;
    cur = {clk_mode, sub_b, div_en, enh_en, ext_bits, div_reg};
    if (rst) begin
      pre_c = 0; s16_c = 0; post_c = 0; prev_cfg = 0;
      e_rx = 0; e_tx = 0; e_sm = 0;
      return;
    end
    if (cur != prev_cfg) begin
      prev_cfg = cur;
      pre_c = 0; s16_c = 0; post_c = 0;
      e_rx = 0; e_tx = 0; e_sm = 0;
      return;
    end
    case (clk_mode)
      3'd2, 3'd3: src = rx_pin_tick;
      3'd0, 3'd6, 3'd7: src = xtal_tick;
      default: src = 0;
    endcase
    g = 0; p = 0;
    if (src) begin
      pre_c++;
      if (pre_c >= factor()) begin
        pre_c = 0; s16_c++;
        if (s16_c >= 16) begin
          s16_c = 0; g = 1; post_c++;
          if (post_c >= 16) begin post_c = 0; p = 1; end
        end
      end
    end
    e_sm = 0;
    case (clk_mode)
      3'd0: begin e_rx = rx_pin_tick; e_tx = sub_b ? g : tx_pin_tick; end
      3'd1, 3'd5: begin e_rx = rx_pin_tick; e_tx = rx_pin_tick; end
      3'd4: begin e_rx = xtal_tick; e_tx = xtal_tick; end
      3'd2, 3'd6: begin e_rx = p; e_tx = sub_b ? p : tx_pin_tick; e_sm = g; end
      default: begin e_rx = sub_b ? g : p; e_tx = e_rx; e_sm = g; end
    endcase
  endtask

  task automatic chk(string tag, string nm_s, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, nm_s, act, exp, $time);
    end
  endtask

  task automatic chk_int(string tag, string nm_s, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, nm_s, act, exp);
    end
  endtask

  int c_rx, c_tx, c_sm;

  task automatic run(int n, string tag, int prx, int ptx, int pxt);
    c_rx = 0; c_tx = 0; c_sm = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk(tag, "rx_bit_en", rx_bit_en, e_rx);
      chk(tag, "tx_bit_en", tx_bit_en, e_tx);
      chk(tag, "samp16_en", samp16_en, e_sm);
      if (i > 0) begin
        c_rx += int'(rx_bit_en); c_tx += int'(tx_bit_en); c_sm += int'(samp16_en);
      end
      rx_pin_tick = ($urandom_range(99) < prx);
      tx_pin_tick = ($urandom_range(99) < ptx);
      xtal_tick   = ($urandom_range(99) < pxt);
      rst = nr; clk_mode = nm; sub_b = ns; div_en = nd; enh_en = ne;
      ext_bits = nx; div_reg = nv;
      model_step();
    end
  endtask

  task automatic cfg(logic [2:0] m, logic s, logic d, logic e, logic [1:0] x, logic [7:0] v);
    nm = m; ns = s; nd = d; ne = e; nx = x; nv = v;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset holds outputs low even with ticks present
    cfg(3'd4, 0, 0, 0, 0, 0);
    run(6, "R1", 100, 100, 100);
    chk_int("R1", "pulses in reset", c_rx + c_tx + c_sm, 0);
    nr = 0;

    // R2: k = 1, mode 3b rx-pin driven, 160 counted ticks -> 10 pulses
    cfg(3'd3, 1, 0, 0, 0, 0);
    run(162, "R2", 100, 0, 0);
    chk_int("R2", "rx pulses k=1", c_rx, 10);
    chk_int("R8", "tx equals rx count", c_tx, 10);
    chk_int("R10", "samp pulses", c_sm, 10);

    // R3: standard N=1 -> k=4, 64 ticks per pulse
    cfg(3'd3, 1, 1, 0, 2'b00, 8'd1);
    run(258, "R3", 100, 0, 0);
    chk_int("R3", "rx pulses N=1", c_rx, 4);

    // R3: high bits, N=256 -> k=514, 8224 ticks per pulse
    cfg(3'd3, 1, 1, 0, 2'b01, 8'd0);
    run(2 * 8224 + 2, "R3", 100, 0, 0);
    chk_int("R3", "rx pulses N=256", c_rx, 2);

    // R4: enhanced, M=0 treated as 1, N=0 -> k=2, mode 7b oscillator
    cfg(3'd7, 1, 1, 1, 2'b00, 8'd0);
    run(32 * 5 + 2, "R4", 0, 0, 100);
    chk_int("R4", "pulses M=0", c_rx, 5);

    // R4: N=1, M={0,1}=... div_reg=8'h41 -> N=1, M=1 -> k=4; ext=1 -> M=5 -> k=20
    cfg(3'd7, 1, 1, 1, 2'b01, 8'h41);
    run(320 * 3 + 2, "R4", 0, 0, 100);
    chk_int("R4", "pulses k=20", c_rx, 3);

    // R7: mode 2a, k=1: 256 ticks per rx bit
    cfg(3'd2, 0, 0, 0, 0, 0);
    run(512 + 2, "R7", 100, 50, 0);
    chk_int("R7", "rx bits mode2", c_rx, 2);
    chk_int("R10", "samp mode2", c_sm, 32);

    // R8: mode 3a, /16 further
    cfg(3'd3, 0, 0, 0, 0, 0);
    run(512 + 2, "R8", 100, 0, 0);
    chk_int("R8", "rx bits mode3a", c_rx, 2);

    // R5: mode 0 both variants, random ticks
    cfg(3'd0, 0, 0, 0, 0, 0);
    run(300, "R5", 40, 60, 70);
    cfg(3'd0, 1, 1, 0, 0, 8'd2);
    run(600, "R5", 40, 60, 100);
    // R6, R9: direct pin modes
    cfg(3'd1, 0, 0, 0, 0, 0);
    run(200, "R6", 50, 50, 50);
    cfg(3'd4, 1, 0, 0, 0, 0);
    run(200, "R9", 50, 50, 50);
    cfg(3'd5, 0, 0, 0, 0, 0);
    run(200, "R9", 50, 50, 50);
    // R7: mode 6b oscillator driven, R11 latency checked each cycle
    cfg(3'd6, 1, 1, 1, 2'b00, 8'd0);
    run(2000, "R11", 30, 30, 80);

    // R12: repeated configuration changes with random ticks
    for (int j = 0; j < 40; j++) begin
      cfg(3'($urandom_range(7)), 1'($urandom_range(1)), 1'($urandom_range(1)),
          1'($urandom_range(1)), 2'b00, 8'($urandom_range(3)));
      run(37, "R12", 70, 50, 70);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule